// File: doc/BRIEF.md
# Command Queue Trigger Sequencer

This block decides when words are pulled from a command queue and handed to a serial transmitter. It keeps a read pointer into the queue and presents the addressed word to the transmitter. Each transfer is tracked from the moment the transmitter accepts the word until the transmitter reports that it has finished sending it. A three-state status (idle, waiting, triggered) governs the flow. The mode input selects how the queue moves from waiting to triggered. There are three trigger kinds: a software trigger, a rising edge on the synchronised trigger pin, or a level on that pin treated as a gate. Each kind comes in a single-scan form and a continuous-scan form.

Every command word carries two control bits. The top bit marks the end of the queue. The bit below it asks the queue to pause. Two sticky flags record these events: an end-of-queue flag and a pause flag. Each flag is cleared by a write-one pulse and drives an interrupt request through its own enable. In level-gated modes the pause bit in the word has no effect. There the pause flag instead reports that the gate closed while the queue was triggered. A gate that closes during a transmission only takes effect once that transmission completes.

Top module: `cmdq_trig_seq`

## Requirements
- R1: After reset `status` is 0 (idle) and all flags, interrupts and `tx_valid` are low. The status codes are 0 idle, 1 waiting, 2 triggered. Once a word is accepted (`tx_valid` and `tx_ready`), no new word is offered until `tx_done` arrives.
- R2: In single-scan modes (`mode[2]`=0), completing a word whose bit CMD_W-1 is set returns the queue to idle. It also clears `single_armed` and resets `q_addr` to 0. No word is offered until `arm` is pulsed again.
- R3: `eoq_flag` rises on the clock edge at which `tx_done` ends a transfer whose word has bit CMD_W-1 set.
- R4: In edge modes (`mode[1:0]`=2), completing a word with bit CMD_W-2 set moves the queue to waiting and sets `pause_flag`. `single_armed` stays set.
- R5: In software (`mode[1:0]`=1) and level (`mode[1:0]`=3) modes, bit CMD_W-2 in a word is ignored. `pause_flag` stays clear and the queue stays triggered.
- R6: In level mode, if the gate (`trig_in` low) closes while the queue is triggered and no transfer is in flight, the queue moves to waiting right after synchronisation. `pause_flag` is set and `tx_valid` drops.
- R7: In level mode, if the gate closes during a transfer, the status stays triggered until `tx_done`. The queue then moves to waiting and sets `pause_flag`.
- R8: `eoq_irq` equals `ie_eoq` AND `eoq_flag`. `pause_irq` equals `ie_pause` AND `pause_flag`.
- R9: A one-cycle pulse on `clr_eoq` or `clr_pause` clears that flag. A set in the same cycle wins.
- R10: In continuous modes (`mode[2]`=1), an end-of-queue word returns `q_addr` to 0 and the queue to waiting without `arm`. The software kind re-triggers at once.
- R11: In edge modes, only a rising edge seen while waiting triggers the queue, and a held high level does not. `q_addr` advances by one per completed word and wraps after DEPTH-1.
- R12: With `mode[1:0]`=0 and no transfer in flight, the queue is idle, `q_addr` is 0 and `single_armed` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Bit 2 continuous, bits 1:0 kind (0 off, 1 software, 2 edge, 3 level) |
| arm | input | 1 | Single-scan arm pulse |
| clr_eoq | input | 1 | Write-one clear of eoq_flag |
| clr_pause | input | 1 | Write-one clear of pause_flag |
| ie_eoq | input | 1 | End-of-queue interrupt enable |
| ie_pause | input | 1 | Pause interrupt enable |
| trig_in | input | 1 | Asynchronous trigger / gate pin |
| q_addr | output | AW | Queue read address |
| q_data | input | CMD_W | Queue word at q_addr |
| tx_valid | output | 1 | Word offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts word |
| tx_data | output | CMD_W | Offered word |
| tx_done | input | 1 | Transmission of accepted word finished |
| status | output | 2 | Queue status code |
| single_armed | output | 1 | Single-scan armed status |
| eoq_flag | output | 1 | End-of-queue flag |
| pause_flag | output | 1 | Pause / gate-closed flag |
| eoq_irq | output | 1 | End-of-queue interrupt request |
| pause_irq | output | 1 | Pause interrupt request |

## Verification
A stale read pointer shows up on `tx_data` at the very next offer, because the bench compares every offered word with its own model of the queue position. A wrong status shows up in one of two ways. Either `tx_valid` rises when the model expects silence, or it stays low until the transfer wait gives up, within a few hundred cycles. A lost or early gate-close decision is visible in the same clock that `tx_done` is processed, through `status` and `pause_flag`.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TRIG = 2'd2
  } qstat_t;

  typedef enum logic [1:0] {
    TK_OFF   = 2'd0,
    TK_SW    = 2'd1,
    TK_EDGE  = 2'd2,
    TK_LEVEL = 2'd3
  } tkind_t;

  function automatic tkind_t mode_kind(input logic [2:0] m);
    return tkind_t'(m[1:0]);
  endfunction

  function automatic logic mode_cont(input logic [2:0] m);
    return m[2];
  endfunction

  // pause bit in a command word is acted on only by edge-trigger kinds
  function automatic logic pause_honoured(input tkind_t k);
    return k == TK_EDGE;
  endfunction

endpackage

// File: rtl/cqs_trig_cond.sv
module cqs_trig_cond #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic lvl,
  output logic rise
);
  logic [SYNC-1:0] sh_q;
  logic            lvl_d_q;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= trig_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC-2:0], trig_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d_q <= 1'b0;
    else        lvl_d_q <= sh_q[SYNC-1];
  end

  assign lvl  = sh_q[SYNC-1];
  assign rise = lvl & ~lvl_d_q;

  // a rising edge is a single-cycle event
  assert_rise_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/cqs_xfer.sv
module cqs_xfer #(
  parameter int CMD_W     = 16,
  parameter int EOQ_BIT   = CMD_W - 1,
  parameter int PAUSE_BIT = CMD_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_ok,
  input  logic [CMD_W-1:0] q_data,
  input  logic             tx_ready,
  input  logic             tx_done,
  input  logic             gate_closed,
  output logic             tx_valid,
  output logic [CMD_W-1:0] tx_data,
  output logic             busy,
  output logic             done_evt,
  output logic             done_eoq,
  output logic             done_pause,
  output logic             close_end
);
  logic busy_q;
  logic eoq_q, pause_q;
  logic seen_q;
  logic start_evt;

  assign tx_valid  = issue_ok & ~busy_q;
  assign tx_data   = q_data;
  assign start_evt = tx_valid & tx_ready;
  assign done_evt  = busy_q & tx_done;
  assign busy      = busy_q;
  assign done_eoq  = eoq_q;
  assign done_pause = pause_q;
  // gate closed at any point of the flight, including the final cycle
  assign close_end = seen_q | gate_closed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      eoq_q   <= 1'b0;
      pause_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (start_evt) begin
        busy_q  <= 1'b1;
        eoq_q   <= q_data[EOQ_BIT];
        pause_q <= q_data[PAUSE_BIT];
        seen_q  <= 1'b0;
      end else begin
        if (done_evt) busy_q <= 1'b0;
        if (busy_q && gate_closed) seen_q <= 1'b1;
      end
    end
  end

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && !tx_valid));

  assert_done_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);

endmodule

// File: rtl/cqs_flags.sv
module cqs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_eoq,
  input  logic set_pause,
  input  logic clr_eoq,
  input  logic clr_pause,
  input  logic ie_eoq,
  input  logic ie_pause,
  output logic eoq_flag,
  output logic pause_flag,
  output logic eoq_irq,
  output logic pause_irq
);
  localparam int NF = 2;

  logic [NF-1:0] set_v, clr_v, ie_v, flag_q, irq_v;

  assign set_v = {set_pause, set_eoq};
  assign clr_v = {clr_pause, clr_eoq};
  assign ie_v  = {ie_pause, ie_eoq};

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_v[i]) flag_q[i] <= 1'b1;
      else if (clr_v[i]) flag_q[i] <= 1'b0;
    end
    assign irq_v[i] = ie_v[i] & flag_q[i];

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> flag_q[i]);

    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[i] && !set_v[i]) |=> !flag_q[i]);
  end

  assign eoq_flag   = flag_q[0];
  assign pause_flag = flag_q[1];
  assign eoq_irq    = irq_v[0];
  assign pause_irq  = irq_v[1];

endmodule

// File: rtl/cqs_ctrl.sv
module cqs_ctrl
  import cqs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          arm,
  input  logic          rise,
  input  logic          lvl,
  input  logic          busy,
  input  logic          done_evt,
  input  logic          done_eoq,
  input  logic          done_pause,
  input  logic          close_end,
  output logic [1:0]    status,
  output logic [AW-1:0] ptr,
  output logic          sss,
  output logic          issue_ok,
  output logic          set_eoq,
  output logic          set_pause
);
  qstat_t        st_q, st_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic          sss_q, sss_n;
  tkind_t        kind;
  logic          cont;
  logic          trig_now;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign kind = mode_kind(mode);
  assign cont = mode_cont(mode);

  always_comb begin
    unique case (kind)
      TK_SW:    trig_now = 1'b1;
      TK_EDGE:  trig_now = rise;
      TK_LEVEL: trig_now = lvl;
      default:  trig_now = 1'b0;
    endcase
  end

  always_comb begin
    st_n      = st_q;
    ptr_n     = ptr_q;
    sss_n     = sss_q;
    set_eoq   = 1'b0;
    set_pause = 1'b0;
    if (arm && kind != TK_OFF && !cont) sss_n = 1'b1;
    if (done_evt) begin
      ptr_n     = done_eoq ? '0 : ptr_step(ptr_q);
      set_eoq   = done_eoq;
      set_pause = (pause_honoured(kind) && done_pause) ||
                  (kind == TK_LEVEL && !done_eoq && close_end);
      if (done_eoq) begin
        if (cont) st_n = ST_WAIT;
        else begin
          st_n  = ST_IDLE;
          sss_n = 1'b0;
        end
      end else if (set_pause) begin
        st_n = ST_WAIT;
      end
    end else if (!busy) begin
      if (kind == TK_OFF) begin
        st_n  = ST_IDLE;
        ptr_n = '0;
        sss_n = 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (cont || sss_q) st_n = ST_WAIT;
          ST_WAIT: if (trig_now) st_n = ST_TRIG;
          ST_TRIG: if (kind == TK_LEVEL && !lvl) begin
            st_n      = ST_WAIT;
            set_pause = 1'b1;
          end
          default: st_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      sss_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      ptr_q <= ptr_n;
      sss_q <= sss_n;
    end
  end

  assign issue_ok = (st_q == ST_TRIG) && (kind != TK_OFF) &&
                    !(kind == TK_LEVEL && !lvl);
  assign status   = st_q;
  assign ptr      = ptr_q;
  assign sss      = sss_q;

  assert_ss_eoq_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && done_eoq && !cont && !arm) |=> (st_q == ST_IDLE && !sss_q && ptr_q == '0));

  assert_cs_eoq_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && done_eoq && cont) |=> (st_q == ST_WAIT && ptr_q == '0));

  assert_edge_pause_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !done_eoq && done_pause && kind == TK_EDGE) |=> (st_q == ST_WAIT));

  assert_pause_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !done_eoq && (kind == TK_SW || kind == TK_LEVEL) && !close_end)
      |=> (st_q == ST_TRIG));

  assert_gate_close_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && st_q == ST_TRIG && kind == TK_LEVEL && !lvl) |=> (st_q == ST_WAIT));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt && st_q == ST_TRIG) |=> (st_q == ST_TRIG));

  assert_ptr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !done_eoq) |=> (ptr_q == ptr_step($past(ptr_q))));

  assert_off_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TK_OFF && !busy) |=> (st_q == ST_IDLE && ptr_q == '0 && !sss_q));

endmodule

// File: rtl/cmdq_trig_seq.sv
module cmdq_trig_seq #(
  parameter int DEPTH = 8,
  parameter int CMD_W = 16,
  parameter int SYNC  = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             arm,
  input  logic             clr_eoq,
  input  logic             clr_pause,
  input  logic             ie_eoq,
  input  logic             ie_pause,
  input  logic             trig_in,
  output logic [AW-1:0]    q_addr,
  input  logic [CMD_W-1:0] q_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [CMD_W-1:0] tx_data,
  input  logic             tx_done,
  output logic [1:0]       status,
  output logic             single_armed,
  output logic             eoq_flag,
  output logic             pause_flag,
  output logic             eoq_irq,
  output logic             pause_irq
);
  localparam int EOQ_BIT   = CMD_W - 1;
  localparam int PAUSE_BIT = CMD_W - 2;

  logic lvl, rise;
  logic busy, done_evt, done_eoq, done_pause, close_end;
  logic issue_ok, set_eoq, set_pause;

  cqs_trig_cond #(.SYNC(SYNC)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .lvl     (lvl),
    .rise    (rise)
  );

  cqs_xfer #(.CMD_W(CMD_W), .EOQ_BIT(EOQ_BIT), .PAUSE_BIT(PAUSE_BIT)) u_xfer (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_ok    (issue_ok),
    .q_data      (q_data),
    .tx_ready    (tx_ready),
    .tx_done     (tx_done),
    .gate_closed (~lvl),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .busy        (busy),
    .done_evt    (done_evt),
    .done_eoq    (done_eoq),
    .done_pause  (done_pause),
    .close_end   (close_end)
  );

  cqs_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .arm        (arm),
    .rise       (rise),
    .lvl        (lvl),
    .busy       (busy),
    .done_evt   (done_evt),
    .done_eoq   (done_eoq),
    .done_pause (done_pause),
    .close_end  (close_end),
    .status     (status),
    .ptr        (q_addr),
    .sss        (single_armed),
    .issue_ok   (issue_ok),
    .set_eoq    (set_eoq),
    .set_pause  (set_pause)
  );

  cqs_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_eoq    (set_eoq),
    .set_pause  (set_pause),
    .clr_eoq    (clr_eoq),
    .clr_pause  (clr_pause),
    .ie_eoq     (ie_eoq),
    .ie_pause   (ie_pause),
    .eoq_flag   (eoq_flag),
    .pause_flag (pause_flag),
    .eoq_irq    (eoq_irq),
    .pause_irq  (pause_irq)
  );

endmodule

// File: tb/tb_cmdq_trig_seq.sv
`timescale 1ns/1ps
module tb_cmdq_trig_seq;
  localparam int DEPTH = 8;
  localparam int CMD_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic arm = 1'b0, clr_eoq = 1'b0, clr_pause = 1'b0;
  logic ie_eoq = 1'b0, ie_pause = 1'b0, trig_in = 1'b0;
  logic [2:0] q_addr;
  logic [CMD_W-1:0] q_data, tx_data;
  logic tx_valid, tx_ready = 1'b0, tx_done = 1'b0;
  logic [1:0] status;
  logic single_armed, eoq_flag, pause_flag, eoq_irq, pause_irq;

  logic [CMD_W-1:0] mem [DEPTH];
  int nchk = 0;
  int nfail = 0;

  assign q_data = mem[q_addr];

  always #2.5 clk = ~clk;

  cmdq_trig_seq #(.DEPTH(DEPTH), .CMD_W(CMD_W), .SYNC(2)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .arm(arm), .clr_eoq(clr_eoq),
    .clr_pause(clr_pause), .ie_eoq(ie_eoq), .ie_pause(ie_pause),
    .trig_in(trig_in), .q_addr(q_addr), .q_data(q_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_done(tx_done), .status(status),
    .single_armed(single_armed), .eoq_flag(eoq_flag), .pause_flag(pause_flag),
    .eoq_irq(eoq_irq), .pause_irq(pause_irq)
  );

  function automatic logic [CMD_W-1:0] mk(input logic e, input logic p, input logic [13:0] pl);
    return {e, p, pl};
  endfunction

  function automatic int next_pos(input int p, input logic e);
    if (e) return 0;
    return (p + 1) % DEPTH;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_clr(input bit e, input bit p);
    clr_eoq = e; clr_pause = p;
    @(negedge clk);
    clr_eoq = 1'b0; clr_pause = 1'b0;
  endtask

  // wait for an offer, check the word, accept, finish it
  task automatic serve(input logic [CMD_W-1:0] exp, input string tag, input bit close_gate);
    bit seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_valid) begin seen = 1; break; end
    end
    chk({tag, " offer seen"}, 32'(seen), 32'd1);
    if (!seen) return;
    chk({tag, " tx_data"}, 32'(tx_data), 32'(exp));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R1 no offer in flight", 32'(tx_valid), 32'd0);
    if (close_gate) begin
      trig_in = 1'b0;
      cyc(5);
      chk("R7 status held during flight", 32'(status), 32'd2);
    end else begin
      cyc($urandom % 3);
    end
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic edge_trig();
    trig_in = 1'b0;
    cyc(3);
    trig_in = 1'b1;
  endtask

  initial begin
    int p;
    bit waiting;
    bit any_pause;
    void'($urandom(32'h5EED));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", 32'(status), 32'd0);
    chk("R1 reset tx_valid", 32'(tx_valid), 32'd0);
    chk("R1 reset flags", {30'd0, eoq_flag, pause_flag}, 32'd0);
    chk("R1 reset irqs", {30'd0, eoq_irq, pause_irq}, 32'd0);

    // single-scan software trigger, pause bit ignored
    mem[0] = mk(0, 0, 14'h0011);
    mem[1] = mk(0, 1, 14'h0022);
    mem[2] = mk(1, 0, 14'h0033);
    mode = 3'b001;
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    serve(mem[0], "R2 ss sw w0", 0);
    serve(mem[1], "R5 ss sw w1", 0);
    chk("R5 sw pause ignored flag", 32'(pause_flag), 32'd0);
    chk("R5 sw pause ignored status", 32'(status), 32'd2);
    serve(mem[2], "R2 ss sw w2", 0);
    chk("R2 idle after eoq", 32'(status), 32'd0);
    chk("R2 armed cleared", 32'(single_armed), 32'd0);
    chk("R2 addr back to 0", 32'(q_addr), 32'd0);
    chk("R3 eoq flag set", 32'(eoq_flag), 32'd1);
    chk("R8 eoq irq masked", 32'(eoq_irq), 32'd0);
    cyc(10);
    chk("R2 no offer without arm", 32'(tx_valid), 32'd0);
    ie_eoq = 1'b1; @(negedge clk);
    chk("R8 eoq irq enabled", 32'(eoq_irq), 32'd1);
    pulse_clr(1, 0);
    chk("R9 eoq cleared", 32'(eoq_flag), 32'd0);
    chk("R8 eoq irq after clear", 32'(eoq_irq), 32'd0);

    // single-scan edge with a pause stop
    mem[0] = mk(0, 0, 14'h0101);
    mem[1] = mk(0, 1, 14'h0202);
    mem[2] = mk(0, 0, 14'h0303);
    mem[3] = mk(1, 0, 14'h0404);
    mode = 3'b000; cyc(3);
    chk("R12 off idle", 32'(status), 32'd0);
    chk("R12 off addr", 32'(q_addr), 32'd0);
    mode = 3'b010;
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    cyc(3);
    chk("R1 waiting code", 32'(status), 32'd1);
    cyc(6);
    chk("R11 no offer before edge", 32'(tx_valid), 32'd0);
    trig_in = 1'b1;
    serve(mem[0], "R11 ss edge w0", 0);
    serve(mem[1], "R4 ss edge w1", 0);
    chk("R4 paused to waiting", 32'(status), 32'd1);
    chk("R4 pause flag", 32'(pause_flag), 32'd1);
    chk("R4 armed kept", 32'(single_armed), 32'd1);
    cyc(6);
    chk("R11 held level no retrigger", 32'(tx_valid), 32'd0);
    ie_pause = 1'b1; @(negedge clk);
    chk("R8 pause irq", 32'(pause_irq), 32'd1);
    edge_trig();
    serve(mem[2], "R11 ss edge w2", 0);
    serve(mem[3], "R2 ss edge w3", 0);
    chk("R2 edge idle after eoq", 32'(status), 32'd0);
    pulse_clr(1, 1);
    chk("R9 pause cleared", 32'(pause_flag), 32'd0);

    // continuous level gate
    mode = 3'b000; trig_in = 1'b0; cyc(3);
    mem[0] = mk(0, 1, 14'h0aa0);
    mem[1] = mk(0, 0, 14'h0aa1);
    mem[2] = mk(0, 0, 14'h0aa2);
    mem[3] = mk(0, 0, 14'h0aa3);
    mode = 3'b111; cyc(5);
    chk("R6 gate closed waiting", 32'(status), 32'd1);
    chk("R6 gate closed no offer", 32'(tx_valid), 32'd0);
    trig_in = 1'b1;
    serve(mem[0], "R5 level w0", 0);
    chk("R5 level pause ignored", 32'(pause_flag), 32'd0);
    chk("R5 level still triggered", 32'(status), 32'd2);
    serve(mem[1], "R5 level w1", 0);
    trig_in = 1'b0;
    cyc(4);
    chk("R6 close idle -> waiting", 32'(status), 32'd1);
    chk("R6 close sets pause", 32'(pause_flag), 32'd1);
    chk("R6 offer dropped", 32'(tx_valid), 32'd0);
    chk("R6 addr kept", 32'(q_addr), 32'd2);
    pulse_clr(0, 1);
    chk("R9 pause cleared again", 32'(pause_flag), 32'd0);
    trig_in = 1'b1;
    serve(mem[2], "R7 level w2", 1);
    chk("R7 waiting after done", 32'(status), 32'd1);
    chk("R7 pause after done", 32'(pause_flag), 32'd1);
    chk("R7 addr advanced", 32'(q_addr), 32'd3);

    // continuous software, random words
    mode = 3'b000; cyc(3);
    pulse_clr(1, 1);
    for (int i = 0; i < DEPTH; i++)
      mem[i] = mk(($urandom % 4) == 0, $urandom % 2, 14'($urandom));
    mem[5][CMD_W-1] = 1'b1;
    mode = 3'b101;
    p = 0;
    for (int k = 0; k < 20; k++) begin
      logic [CMD_W-1:0] w;
      w = mem[p];
      serve(w, "R10 cs sw word", 0);
      if (w[CMD_W-1]) begin
        chk("R10 cs eoq addr 0", 32'(q_addr), 32'd0);
        chk("R3 cs eoq flag", 32'(eoq_flag), 32'd1);
      end
      chk("R10 cs not idle", 32'(status != 2'd0), 32'd1);
      p = next_pos(p, w[CMD_W-1]);
    end
    chk("R5 random sw pause flag", 32'(pause_flag), 32'd0);

    // continuous edge, random pause, wraps past DEPTH
    mode = 3'b000; trig_in = 1'b0; cyc(3);
    pulse_clr(1, 1);
    any_pause = 0;
    for (int i = 0; i < DEPTH; i++)
      mem[i] = mk(1'b0, ($urandom % 3) == 0, 14'($urandom));
    mode = 3'b110;
    cyc(2);
    p = 0; waiting = 1;
    for (int k = 0; k < 12; k++) begin
      logic [CMD_W-1:0] w;
      w = mem[p];
      if (waiting) edge_trig();
      serve(w, "R11 cs edge word", 0);
      any_pause |= w[CMD_W-2];
      waiting = w[CMD_W-2];
      chk("R4 cs edge status", 32'(status), waiting ? 32'd1 : 32'd2);
      p = next_pos(p, 1'b0);
      chk("R11 addr wrap step", 32'(q_addr), 32'(p));
    end
    chk("R4 cs edge pause flag", 32'(pause_flag), 32'(any_pause));

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule